// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel

This block is the memory-side DMA engine that sits next to a SCSI protocol core. Software programs a start count, a start address and a start descriptor-list address. It then issues a start command, which loads the working copies of those values and lets the core begin moving data. Each time the core asks for a burst, the channel clamps the burst to the bytes still owed. It grants the burst at the working address and then advances the working address and reduces the working count.

The channel merges the core's interrupt line with its own DMA-done condition into a single interrupt output. The status flags that software acknowledges can be cleared in one of two ways, chosen by a mode bit in a separate bus/control register: by reading status, or by writing ones to status. Abort sends a one-cycle cancel pulse to the core. Idle withdraws the transfer enable.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset every register index reads zero, except index 4 (working address), which reads 0xFFFFFFFF, and index 7 (working descriptor address), which reads 0xFFFFFFFD. The outputs irq, xfer_en, core_cancel and burst_gnt are all low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address and 7 working descriptor address. Indices 1, 2 and 6 store what is written. Writes to indices 3, 4 and 7 change nothing.
- R3: Command bits [1:0] encode the operation: 0 idle, 1 blast, 2 abort, 3 start. Writing a start command loads the working count from the start count, the working address from the start address and the working descriptor address from the start descriptor address. It also clears status bits [5:0] and raises xfer_en.
- R4: A granted burst has length min(burst_len, working count) and address equal to the working address. At the edge that ends the grant cycle, the working count drops by that length and the working address rises by it.
- R5: Command bit 7 set means device-to-memory. A burst request whose burst_to_mem differs from bit 7 is not granted and leaves the counters unchanged.
- R6: A rising core_irq sets status bit 4 (core interrupt). A falling core_irq clears it.
- R7: On a rising core_irq, status bit 3 (done) is set if the command operation is start and the working count is zero. If the working count is nonzero, bit 3 stays clear.
- R8: irq is high exactly when status bit 4 is set, or when command bit 6 (done interrupt enable) and status bit 3 are both set.
- R9: With bus/control bit 24 clear, a status read returns the current value, and the read then clears status bits 1 to 3.
- R10: With bus/control bit 24 set, status reads have no side effect. A status write clears each of bits 1 to 3 that is written as one.
- R11: Writing an abort command pulses core_cancel high for one cycle, starting one cycle after the write, and leaves the counters unchanged. Blast changes neither counters nor xfer_en. Idle drops xfer_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_sel | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| ctl_wr | input | 1 | Bus/control register write strobe |
| ctl_wdata | input | 32 | Bus/control register write data |
| ctl_rdata | output | 32 | Bus/control register contents |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| irq | output | 1 | Merged interrupt output |
| xfer_en | output | 1 | Transfer enable toward the SCSI core |
| core_cancel | output | 1 | One-cycle cancel pulse toward the SCSI core |
| burst_req | input | 1 | Burst request from the core |
| burst_to_mem | input | 1 | Burst direction, 1 = device to memory |
| burst_len | input | 16 | Requested burst length in bytes |
| burst_gnt | output | 1 | Burst granted this cycle |
| burst_gnt_len | output | 32 | Granted (clamped) burst length |
| burst_addr | output | 32 | Memory address of the granted burst |

## Verification
The checker watches several rules on every cycle: that a granted burst never exceeds the working count or the requested length, that a burst in the wrong direction is never granted, that the working count falls by exactly the granted length, that a rising core interrupt is followed by a high irq, that a falling one with the done enable off drops irq, and that each cancel pulse traces back to an abort write. Only the bench's scenarios can show the rest. That covers the reset values, the register map, the copy performed by start, and whether done is set depending on the remaining count. It also covers the difference between the clear-on-read and write-one-to-clear modes and the behaviour of the idle and blast commands.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] IX_CMD   = 3'd0;
  localparam logic [SEL_W-1:0] IX_SCNT  = 3'd1;
  localparam logic [SEL_W-1:0] IX_SADR  = 3'd2;
  localparam logic [SEL_W-1:0] IX_WCNT  = 3'd3;
  localparam logic [SEL_W-1:0] IX_WADR  = 3'd4;
  localparam logic [SEL_W-1:0] IX_STAT  = 3'd5;
  localparam logic [SEL_W-1:0] IX_SDSC  = 3'd6;
  localparam logic [SEL_W-1:0] IX_WDSC  = 3'd7;

  localparam int STAT_W     = 6;
  localparam int ST_CORE    = 4;
  localparam int ST_DONE    = 3;
  localparam int CMD_DONEIE = 6;
  localparam int CMD_DIR    = 7;
  localparam int CTL_W1C    = 24;
endpackage

// File: rtl/dma_burst_clamp.sv
module dma_burst_clamp #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              req,
  input  logic              to_mem,
  input  logic              dir_cmd,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] wcnt,
  input  logic [DATA_W-1:0] waddr,
  output logic              gnt,
  output logic [DATA_W-1:0] gnt_len,
  output logic [DATA_W-1:0] gnt_addr
);
  logic [DATA_W-1:0] len_ext;

  always_comb begin
    len_ext  = DATA_W'(req_len);
    gnt      = req && (to_mem == dir_cmd);
    gnt_len  = '0;
    if (gnt) begin
      gnt_len = (len_ext < wcnt) ? len_ext : wcnt;
    end
    gnt_addr = waddr;
  end
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_clr,
  input  logic              rd_clr,
  input  logic              w1c_en,
  input  logic [STAT_W-1:0] w1c_bits,
  input  logic              core_irq,
  input  logic              op_is_start,
  input  logic              wcnt_zero,
  input  logic              done_ie,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              core_q;
  logic              rise, fall;

  assign rise = core_irq && !core_q;
  assign fall = !core_irq && core_q;

  always_comb begin
    stat_d = stat_q;
    if (start_clr) stat_d = '0;
    if (rd_clr)    stat_d[3:1] = 3'b000;
    if (w1c_en)    stat_d[3:1] = stat_d[3:1] & ~w1c_bits[3:1];
    if (rise) begin
      stat_d[ST_CORE] = 1'b1;
      if (op_is_start && wcnt_zero) stat_d[ST_DONE] = 1'b1;
    end
    if (fall) stat_d[ST_CORE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      core_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      core_q <= core_irq;
    end
  end

  assign status = stat_q;
  assign irq    = stat_q[ST_CORE] || (done_ie && stat_q[ST_DONE]);
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              core_irq,
  output logic              irq,
  output logic              xfer_en,
  output logic              core_cancel,
  input  logic              burst_req,
  input  logic              burst_to_mem,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              burst_gnt,
  output logic [DATA_W-1:0] burst_gnt_len,
  output logic [DATA_W-1:0] burst_addr
);
  localparam logic [DATA_W-1:0] WADR_RST = '1;
  localparam logic [DATA_W-1:0] WDSC_RST = ~(DATA_W'(2));

  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdsc_q, wdsc_q, ctl_q;
  logic [DATA_W-1:0] cmd_d, scnt_d, sadr_d, wcnt_d, wadr_d, sdsc_d, wdsc_d, ctl_d;
  logic              xfer_q, xfer_d, cancel_q, cancel_d;
  logic [STAT_W-1:0] status;
  logic              wr_cmd, start_go;
  dma_op_e           op_w, op_cur;
  logic              rd_clr, w1c_en;

  assign op_w     = dma_op_e'(reg_wdata[1:0]);
  assign op_cur   = dma_op_e'(cmd_q[1:0]);
  assign wr_cmd   = reg_wr && (reg_sel == IX_CMD);
  assign start_go = wr_cmd && (op_w == OP_START);
  assign rd_clr   = reg_rd && (reg_sel == IX_STAT) && !ctl_q[CTL_W1C];
  assign w1c_en   = reg_wr && (reg_sel == IX_STAT) && ctl_q[CTL_W1C];

  dma_burst_clamp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_clamp (
    .req      (burst_req),
    .to_mem   (burst_to_mem),
    .dir_cmd  (cmd_q[CMD_DIR]),
    .req_len  (burst_len),
    .wcnt     (wcnt_q),
    .waddr    (wadr_q),
    .gnt      (burst_gnt),
    .gnt_len  (burst_gnt_len),
    .gnt_addr (burst_addr)
  );

  dma_stat_irq u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_clr   (start_go),
    .rd_clr      (rd_clr),
    .w1c_en      (w1c_en),
    .w1c_bits    (reg_wdata[STAT_W-1:0]),
    .core_irq    (core_irq),
    .op_is_start (op_cur == OP_START),
    .wcnt_zero   (wcnt_q == '0),
    .done_ie     (cmd_q[CMD_DONEIE]),
    .status      (status),
    .irq         (irq)
  );

  // next-state
  always_comb begin
    cmd_d    = cmd_q;
    scnt_d   = scnt_q;
    sadr_d   = sadr_q;
    sdsc_d   = sdsc_q;
    wcnt_d   = wcnt_q;
    wadr_d   = wadr_q;
    wdsc_d   = wdsc_q;
    ctl_d    = ctl_q;
    xfer_d   = xfer_q;
    cancel_d = wr_cmd && (op_w == OP_ABORT);
    if (reg_wr) begin
      case (reg_sel)
        IX_CMD:  cmd_d  = reg_wdata;
        IX_SCNT: scnt_d = reg_wdata;
        IX_SADR: sadr_d = reg_wdata;
        IX_SDSC: sdsc_d = reg_wdata;
        default: ;
      endcase
    end
    if (ctl_wr) ctl_d = ctl_wdata;
    if (start_go) begin
      wcnt_d = scnt_q;
      wadr_d = sadr_q;
      wdsc_d = sdsc_q;
      xfer_d = 1'b1;
    end else if (burst_gnt) begin
      wcnt_d = wcnt_q - burst_gnt_len;
      wadr_d = wadr_q + burst_gnt_len;
    end
    if (wr_cmd && (op_w == OP_IDLE)) xfer_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      scnt_q   <= '0;
      sadr_q   <= '0;
      sdsc_q   <= '0;
      wcnt_q   <= '0;
      wadr_q   <= WADR_RST;
      wdsc_q   <= WDSC_RST;
      ctl_q    <= '0;
      xfer_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      scnt_q   <= scnt_d;
      sadr_q   <= sadr_d;
      sdsc_q   <= sdsc_d;
      wcnt_q   <= wcnt_d;
      wadr_q   <= wadr_d;
      wdsc_q   <= wdsc_d;
      ctl_q    <= ctl_d;
      xfer_q   <= xfer_d;
      cancel_q <= cancel_d;
    end
  end

  always_comb begin
    case (reg_sel)
      IX_CMD:  reg_rdata = cmd_q;
      IX_SCNT: reg_rdata = scnt_q;
      IX_SADR: reg_rdata = sadr_q;
      IX_WCNT: reg_rdata = wcnt_q;
      IX_WADR: reg_rdata = wadr_q;
      IX_STAT: reg_rdata = DATA_W'(status);
      IX_SDSC: reg_rdata = sdsc_q;
      default: reg_rdata = wdsc_q;
    endcase
  end

  assign ctl_rdata   = ctl_q;
  assign xfer_en     = xfer_q;
  assign core_cancel = cancel_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              core_irq,
  input logic              irq,
  input logic              done_ie,
  input logic              cmd_dir,
  input logic [DATA_W-1:0] wcnt,
  input logic              burst_req,
  input logic              burst_to_mem,
  input logic [LEN_W-1:0]  burst_len,
  input logic              burst_gnt,
  input logic [DATA_W-1:0] burst_gnt_len,
  input logic              core_cancel
);
  a_r4_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gnt |-> (burst_gnt_len <= wcnt) && (burst_gnt_len <= DATA_W'(burst_len)));

  a_r4_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gnt && !(reg_wr && reg_sel == 3'd0) |=> wcnt == $past(wcnt) - $past(burst_gnt_len));

  a_r5_dir_reject: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && (burst_to_mem != cmd_dir) |-> !burst_gnt);

  a_r6_rise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_irq) |=> irq);

  a_r8_fall_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_irq) && !done_ie && !reg_wr |=> !irq);

  a_r11_cancel_src: assert property (@(posedge clk) disable iff (!rst_n)
    core_cancel |-> $past(reg_wr && reg_sel == 3'd0 && reg_wdata[1:0] == 2'd2));
endmodule

bind scsi_dma_chan dma_chan_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_sel       (reg_sel),
  .reg_wdata     (reg_wdata),
  .core_irq      (core_irq),
  .irq           (irq),
  .done_ie       (cmd_q[6]),
  .cmd_dir       (cmd_q[7]),
  .wcnt          (wcnt_q),
  .burst_req     (burst_req),
  .burst_to_mem  (burst_to_mem),
  .burst_len     (burst_len),
  .burst_gnt     (burst_gnt),
  .burst_gnt_len (burst_gnt_len),
  .core_cancel   (core_cancel)
);

// File: tb/sim_scsi_dma_chan.sv
`timescale 1ns/1ps
module sim_scsi_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic        core_irq = 1'b0, irq, xfer_en, core_cancel;
  logic        burst_req = 1'b0, burst_to_mem = 1'b0, burst_gnt;
  logic [15:0] burst_len = '0;
  logic [31:0] burst_gnt_len, burst_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scsi_dma_chan u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel; #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic burst_chk(input bit to_mem, input logic [15:0] len, input bit exp_g,
                           input logic [31:0] exp_len, input logic [31:0] exp_adr, input string req);
    @(negedge clk); burst_req = 1'b1; burst_to_mem = to_mem; burst_len = len; #1;
    chk(burst_gnt === exp_g, req, 32'(burst_gnt), 32'(exp_g));
    if (exp_g) begin
      chk(burst_gnt_len === exp_len, req, burst_gnt_len, exp_len);
      chk(burst_addr === exp_adr, req, burst_addr, exp_adr);
    end
    @(negedge clk); burst_req = 1'b0;
  endtask

  task automatic set_core(input bit v);
    @(negedge clk); core_irq = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(irq === 1'b0 && xfer_en === 1'b0 && core_cancel === 1'b0 && burst_gnt === 1'b0,
        "R1 outputs", {irq, xfer_en, core_cancel, burst_gnt}, 0);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = (i == 4) ? 32'hFFFF_FFFF : (i == 7) ? 32'hFFFF_FFFD : 32'h0;
      rd_chk(3'(i), e, "R1 reset value");
    end
  endtask

  task automatic t_regmap;
    wr(3'd1, 32'h100); wr(3'd2, 32'h8000); wr(3'd6, 32'h55AA_0000);
    wr(3'd3, 32'h1234); wr(3'd4, 32'h5678); wr(3'd7, 32'h9ABC);
    rd_chk(3'd1, 32'h100, "R2 start count");
    rd_chk(3'd2, 32'h8000, "R2 start addr");
    rd_chk(3'd6, 32'h55AA_0000, "R2 start desc");
    rd_chk(3'd3, 32'h0, "R2 wcnt ignored");
    rd_chk(3'd4, 32'hFFFF_FFFF, "R2 waddr ignored");
    rd_chk(3'd7, 32'hFFFF_FFFD, "R2 wdesc ignored");
  endtask

  task automatic t_run_rdclr;
    wr(3'd0, 32'h43);  // start, done IE, memory-to-device
    rd_chk(3'd3, 32'h100, "R3 wcnt loaded");
    rd_chk(3'd4, 32'h8000, "R3 waddr loaded");
    rd_chk(3'd7, 32'h55AA_0000, "R3 wdesc loaded");
    rd_chk(3'd5, 32'h0, "R3 status cleared");
    chk(xfer_en === 1'b1, "R3 xfer_en", 32'(xfer_en), 1);
    burst_chk(1'b1, 16'h40, 1'b0, 0, 0, "R5 wrong dir");
    rd_chk(3'd3, 32'h100, "R5 wcnt unchanged");
    burst_chk(1'b0, 16'h40, 1'b1, 32'h40, 32'h8000, "R4 burst1");
    rd_chk(3'd3, 32'hC0, "R4 wcnt after burst1");
    burst_chk(1'b0, 16'h200, 1'b1, 32'hC0, 32'h8040, "R4 clamp");
    rd_chk(3'd3, 32'h0, "R4 wcnt zero");
    rd_chk(3'd4, 32'h8100, "R4 waddr advanced");
    set_core(1'b1);
    chk(irq === 1'b1, "R6 irq on core rise", 32'(irq), 1);
    set_core(1'b0);
    chk(irq === 1'b1, "R8 done with IE holds irq", 32'(irq), 1);
    rd_chk(3'd5, 32'h08, "R7 done set at zero count");
    rd_chk(3'd5, 32'h00, "R9 read cleared done");
    chk(irq === 1'b0, "R9 irq after read clear", 32'(irq), 0);
  endtask

  task automatic t_run_w1c;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 32'h0100_0000;
    @(negedge clk); ctl_wr = 1'b0;
    chk(ctl_rdata === 32'h0100_0000, "R10 ctl mode", ctl_rdata, 32'h0100_0000);
    wr(3'd1, 32'h10);
    wr(3'd0, 32'h83);  // start, device-to-memory, no done IE
    set_core(1'b1);
    rd_chk(3'd5, 32'h10, "R7 no done with count left");
    set_core(1'b0);
    rd_chk(3'd5, 32'h00, "R6 core bit cleared on fall");
    burst_chk(1'b1, 16'h10, 1'b1, 32'h10, 32'h8000, "R4 dev-to-mem burst");
    set_core(1'b1);
    set_core(1'b0);
    chk(irq === 1'b0, "R8 done without IE", 32'(irq), 0);
    rd_chk(3'd5, 32'h08, "R10 read no side effect");
    rd_chk(3'd5, 32'h08, "R10 second read keeps done");
    wr(3'd5, 32'h08);
    rd_chk(3'd5, 32'h00, "R10 w1c cleared done");
  endtask

  task automatic t_cmds;
    wr(3'd1, 32'h20);
    wr(3'd0, 32'h83);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h82;
    @(negedge clk); reg_wr = 1'b0;
    chk(core_cancel === 1'b1, "R11 cancel pulse", 32'(core_cancel), 1);
    @(negedge clk);
    chk(core_cancel === 1'b0, "R11 cancel one cycle", 32'(core_cancel), 0);
    rd_chk(3'd3, 32'h20, "R11 abort keeps count");
    chk(xfer_en === 1'b1, "R11 abort keeps xfer_en", 32'(xfer_en), 1);
    wr(3'd0, 32'h81);
    rd_chk(3'd3, 32'h20, "R11 blast keeps count");
    chk(xfer_en === 1'b1, "R11 blast keeps xfer_en", 32'(xfer_en), 1);
    wr(3'd0, 32'h80);
    chk(xfer_en === 1'b0, "R11 idle drops xfer_en", 32'(xfer_en), 0);
    rd_chk(3'd0, 32'h80, "R2 command readback");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_run_rdclr();
    t_run_w1c();
    t_cmds();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule